// File: doc/BRIEF.md
# DMA Descriptor Control Sequencer

This block takes the 32-bit control word of a DMA descriptor, together with its source, destination, length and identifying addresses, and runs the address side of one DMA channel. It works out where the destination is. The destination can be a plain address, a register window, a buffer taken from a pool, the address the previous transfer finished at, or a field of the next descriptor in the chain. It then advances or holds the source and destination addresses on each word beat that the data mover reports. It also rejects control words that are illegal before any transfer starts.

When the data mover signals that the transfer has finished, the sequencer issues the actions the control word asks for. It can push an identifier into the DMA event queue, set a completion status bit, and enqueue the buffer base for transmission. The checksum, alignment-clear and byte-order flags are decoded and presented to the datapath while the channel is busy. The datapath does the actual byte movement.

Top module: `dma_desc_seq`

## Requirements
- R1: Control-word decode. When bit 25 is 1, bit 29 holds the destination address and bit 28 holds the source address. When bit 25 is 0, bit 28 drives `cksum_en` and bit 29 drives `cksum_clr`. Bit 27 drives `little_en` (1 means little-endian). These flag outputs are valid while `busy` is high.
- R2: Destination specifier bits 22..20 equal to 000 and 001 use the descriptor destination as given, with `dst_space` 0 (internal memory) and 1 (PCI bus) respectively. 010 keeps only the low 16 bits of the destination and sets `dst_space` to 2 (register).
- R3: Specifier 100 uses the final destination address of the last completed transfer, with that transfer's `dst_space`. This value is 0 and memory space after reset. Specifier 101 uses next-descriptor address + 4, and 110 uses next-descriptor address + 8, both in memory space.
- R4: Specifier 011 asks a buffer pool for a buffer, with the pool ID taken from the low 4 destination bits. `pool_req` is high from the cycle after the load until a grant arrives. A grant with a buffer available starts the transfer at the returned address in memory space. A grant without one raises `zero_dst_evt` for one cycle, and the channel returns to idle without starting.
- R5: Each beat accepted while active adds 4 to the source address and to the destination address, except that a held address stays unchanged. A beat in the same cycle as `done` is not applied.
- R6: On completion a held address advances by 4. The completion-time destination becomes the value that specifier 100 uses later.
- R7: On completion with bit 24 set, `evq_push` pulses with `evq_data` equal to the upper 26 bits of the descriptor identifying address.
- R8: On completion `stat_set` pulses unless bit 23 is set. Bit 23 has no effect on error reporting.
- R9: On completion with bit 26 set, `tx_enq` pulses. `tx_addr` carries the starting destination address with its low 6 bits cleared.
- R10: An illegal load raises `err_pulse` for one cycle and does not start a transfer. The `err_code` values, in priority order, are: 1 = bit 31 or bit 30 nonzero, 2 = specifier 111, 3 = misaligned in little-endian mode, 4 = hold length violation.
- R11: Code 3 applies when bit 27 is set and the source, or the resolved destination (for any specifier other than 011), is not a multiple of 4. Code 4 applies when an address is held and the length exceeds 252 bytes. A length of exactly 252 bytes is accepted.
- R12: A load presented while `busy` is high is ignored and leaves the addresses unchanged. Each of `xfer_start`, `err_pulse` and `zero_dst_evt` is a single-cycle pulse, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Descriptor load strobe |
| ld_ctrl | input | 32 | Control word |
| ld_src | input | 32 | Source address |
| ld_dst | input | 32 | Destination field |
| ld_len | input | 16 | Transfer length in bytes |
| ld_desc_addr | input | 32 | Identifying (system descriptor) address |
| ld_next_desc | input | 32 | Address of the next descriptor in the chain |
| beat | input | 1 | One word moved |
| done | input | 1 | Data mover finished |
| pool_req | output | 1 | Buffer request pending |
| pool_id | output | 4 | Pool selected for the request |
| pool_grant | input | 1 | Pool answer valid |
| pool_avail | input | 1 | A buffer was supplied with the grant |
| pool_addr | input | 32 | Supplied buffer address |
| busy | output | 1 | Channel not idle |
| xfer_start | output | 1 | Transfer may begin |
| cur_src | output | 32 | Current source address |
| cur_dst | output | 32 | Current destination address |
| dst_space | output | 2 | 0 memory, 1 PCI, 2 register |
| cksum_en | output | 1 | Checksum enabled for this segment |
| cksum_clr | output | 1 | Clear checksum and alignment state |
| little_en | output | 1 | Little-endian operation |
| evq_push | output | 1 | Event queue push |
| evq_data | output | 26 | Event identifier |
| stat_set | output | 1 | Completion status set |
| tx_enq | output | 1 | Transmit enqueue |
| tx_addr | output | 32 | Packet base for transmission |
| zero_dst_evt | output | 1 | Pool had no buffer |
| err_pulse | output | 1 | Descriptor rejected |
| err_code | output | 3 | Rejection reason |

## Verification
A load sampled at a clock edge makes `xfer_start` or `err_pulse` visible in the following cycle. For specifier 011, `pool_req` appears in that cycle instead, and `xfer_start` or `zero_dst_evt` follows one cycle after the edge that samples the grant. A beat moves `cur_src`/`cur_dst` one cycle later. `done` produces the completion pulses and the adjusted addresses one cycle later. The driver drives inputs on the falling edge, and the monitor samples outputs on the falling edge. An expectation is queued before the rising edge that creates it, so every pulse is compared in the exact half-cycle where it must appear, and a pulse that appears with nothing queued is counted as a failure.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [2:0] {
      DM_MEM     = 3'd0,
      DM_PCI     = 3'd1,
      DM_REG     = 3'd2,
      DM_POOL    = 3'd3,
      DM_PREV    = 3'd4,
      DM_NXT_SRC = 3'd5,
      DM_NXT_DST = 3'd6,
      DM_RSVD    = 3'd7
   } dst_mode_e;

   typedef enum logic [1:0] {
      SP_MEM = 2'd0,
      SP_PCI = 2'd1,
      SP_REG = 2'd2
   } space_e;

   typedef enum logic [2:0] {
      EC_NONE      = 3'd0,
      EC_RSVD_BITS = 3'd1,
      EC_RSVD_MODE = 3'd2,
      EC_ALIGN     = 3'd3,
      EC_HOLD_LEN  = 3'd4
   } err_code_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_POOL   = 2'd1,
      ST_ACTIVE = 2'd2
   } seq_state_e;

   typedef struct packed {
      logic      rsvd_nz;
      logic      hold_src;
      logic      hold_dst;
      logic      cksum_en;
      logic      cksum_clr;
      logic      little;
      logic      tx_on_done;
      logic      evq_on_done;
      logic      no_status;
      dst_mode_e mode;
   } ctrl_fields_t;

endpackage

// File: rtl/dma_ctrl_decode.sv
module dma_ctrl_decode
   import dma_seq_pkg::*;
(
   input  logic [31:0]  word,
   output ctrl_fields_t fields
);

   logic hold_mode;

   assign hold_mode = word[25];

   always_comb begin
      fields             = '0;
      fields.rsvd_nz     = |word[31:30];
      fields.hold_dst    = hold_mode & word[29];
      fields.hold_src    = hold_mode & word[28];
      fields.cksum_clr   = ~hold_mode & word[29];
      fields.cksum_en    = ~hold_mode & word[28];
      fields.little      = word[27];
      fields.tx_on_done  = word[26];
      fields.evq_on_done = word[24];
      fields.no_status   = word[23];
      fields.mode        = dst_mode_e'(word[22:20]);
   end

endmodule

// File: rtl/dma_desc_check.sv
module dma_desc_check
   import dma_seq_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int WORD_BYTES = 4,
   parameter int HOLD_MAX   = 252
) (
   input  ctrl_fields_t      fields,
   input  logic [ADDR_W-1:0] src,
   input  logic [ADDR_W-1:0] dst,
   input  logic              dst_known,
   input  logic [LEN_W-1:0]  len,
   output err_code_e         code
);

   localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(WORD_BYTES - 1);
   localparam logic [LEN_W-1:0]  LEN_LIMIT  = LEN_W'(HOLD_MAX);

   logic src_off, dst_off, misaligned, too_long;

   assign src_off    = (src & ALIGN_MASK) != '0;
   assign dst_off    = dst_known && ((dst & ALIGN_MASK) != '0);
   assign misaligned = fields.little && (src_off || dst_off);
   assign too_long   = (fields.hold_src || fields.hold_dst) && (len > LEN_LIMIT);

   always_comb begin
      if (fields.rsvd_nz)              code = EC_RSVD_BITS;
      else if (fields.mode == DM_RSVD) code = EC_RSVD_MODE;
      else if (misaligned)             code = EC_ALIGN;
      else if (too_long)               code = EC_HOLD_LEN;
      else                             code = EC_NONE;
   end

endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
   parameter int ADDR_W     = 32,
   parameter int WORD_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_load,
   input  logic [ADDR_W-1:0] src_in,
   input  logic              dst_load,
   input  logic [ADDR_W-1:0] dst_in,
   input  logic              beat_en,
   input  logic              cmpl_en,
   input  logic              hold_src,
   input  logic              hold_dst,
   output logic [ADDR_W-1:0] src_q,
   output logic [ADDR_W-1:0] dst_q,
   output logic [ADDR_W-1:0] base_q,
   output logic [ADDR_W-1:0] last_dst_q
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   logic [ADDR_W-1:0] src_beat, dst_beat, src_fin, dst_fin;

   assign src_beat = hold_src ? src_q : src_q + STEP;
   assign dst_beat = hold_dst ? dst_q : dst_q + STEP;
   assign src_fin  = hold_src ? src_q + STEP : src_q;
   assign dst_fin  = hold_dst ? dst_q + STEP : dst_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q      <= '0;
         dst_q      <= '0;
         base_q     <= '0;
         last_dst_q <= '0;
      end else begin
         if (src_load)     src_q <= src_in;
         else if (cmpl_en) src_q <= src_fin;
         else if (beat_en) src_q <= src_beat;

         if (dst_load) begin
            dst_q  <= dst_in;
            base_q <= dst_in;
         end else if (cmpl_en) begin
            dst_q      <= dst_fin;
            last_dst_q <= dst_fin;
         end else if (beat_en) begin
            dst_q <= dst_beat;
         end
      end
   end

   // R5
   hold_dst_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_en && hold_dst && !dst_load && !cmpl_en) |=> $stable(dst_q));

   // R5
   src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_en && !hold_src && !src_load && !cmpl_en) |=> (src_q == $past(src_q) + STEP));

   // R6
   held_src_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmpl_en && hold_src && !src_load) |=> (src_q == $past(src_q) + STEP));

endmodule

// File: rtl/dma_cmpl_unit.sv
module dma_cmpl_unit #(
   parameter int ADDR_W        = 32,
   parameter int SYS_ADDR_W    = 32,
   parameter int EVQ_W         = 26,
   parameter int TX_ALIGN_BITS = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmpl_en,
   input  logic                  evq_on,
   input  logic                  no_status,
   input  logic                  tx_on,
   input  logic [SYS_ADDR_W-1:0] desc_addr,
   input  logic [ADDR_W-1:0]     base_dst,
   output logic                  evq_push,
   output logic [EVQ_W-1:0]      evq_data,
   output logic                  stat_set,
   output logic                  tx_enq,
   output logic [ADDR_W-1:0]     tx_addr
);

   logic [ADDR_W-1:0] tx_base;

   generate
      if (TX_ALIGN_BITS > 0) begin : g_tx_mask
         assign tx_base = {base_dst[ADDR_W-1:TX_ALIGN_BITS], {TX_ALIGN_BITS{1'b0}}};
      end else begin : g_tx_pass
         assign tx_base = base_dst;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evq_push <= 1'b0;
         evq_data <= '0;
         stat_set <= 1'b0;
         tx_enq   <= 1'b0;
         tx_addr  <= '0;
      end else begin
         evq_push <= cmpl_en && evq_on;
         stat_set <= cmpl_en && !no_status;
         tx_enq   <= cmpl_en && tx_on;
         if (cmpl_en) begin
            evq_data <= desc_addr[SYS_ADDR_W-1 -: EVQ_W];
            tx_addr  <= tx_base;
         end
      end
   end

   // R8
   status_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmpl_en && !no_status) |=> stat_set);

   // R8
   status_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmpl_en && no_status) |=> !stat_set);

   // R7
   evq_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmpl_en && evq_on) |=> evq_push);

   // R9
   tx_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmpl_en |=> !tx_enq);

endmodule

// File: rtl/dma_desc_seq.sv
module dma_desc_seq
   import dma_seq_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int SYS_ADDR_W    = 32,
   parameter int LEN_W         = 16,
   parameter int WORD_BYTES    = 4,
   parameter int HOLD_MAX      = 252,
   parameter int POOL_ID_W     = 4,
   parameter int REG_ADDR_W    = 16,
   parameter int EVQ_W         = 26,
   parameter int TX_ALIGN_BITS = 6,
   parameter int SRC_FIELD_OFS = 4,
   parameter int DST_FIELD_OFS = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ld_valid,
   input  logic [31:0]           ld_ctrl,
   input  logic [ADDR_W-1:0]     ld_src,
   input  logic [ADDR_W-1:0]     ld_dst,
   input  logic [LEN_W-1:0]      ld_len,
   input  logic [SYS_ADDR_W-1:0] ld_desc_addr,
   input  logic [ADDR_W-1:0]     ld_next_desc,
   input  logic                  beat,
   input  logic                  done,
   output logic                  pool_req,
   output logic [POOL_ID_W-1:0]  pool_id,
   input  logic                  pool_grant,
   input  logic                  pool_avail,
   input  logic [ADDR_W-1:0]     pool_addr,
   output logic                  busy,
   output logic                  xfer_start,
   output logic [ADDR_W-1:0]     cur_src,
   output logic [ADDR_W-1:0]     cur_dst,
   output logic [1:0]            dst_space,
   output logic                  cksum_en,
   output logic                  cksum_clr,
   output logic                  little_en,
   output logic                  evq_push,
   output logic [EVQ_W-1:0]      evq_data,
   output logic                  stat_set,
   output logic                  tx_enq,
   output logic [ADDR_W-1:0]     tx_addr,
   output logic                  zero_dst_evt,
   output logic                  err_pulse,
   output logic [2:0]            err_code
);

   localparam logic [ADDR_W-1:0] SRC_OFS = ADDR_W'(SRC_FIELD_OFS);
   localparam logic [ADDR_W-1:0] DST_OFS = ADDR_W'(DST_FIELD_OFS);

   generate
      if (EVQ_W > SYS_ADDR_W) begin : g_bad_evq
         $error("EVQ_W must not exceed SYS_ADDR_W");
      end
      if (TX_ALIGN_BITS >= ADDR_W) begin : g_bad_tx
         $error("TX_ALIGN_BITS must be below ADDR_W");
      end
      if (POOL_ID_W > ADDR_W || REG_ADDR_W > ADDR_W) begin : g_bad_fld
         $error("pool ID and register window must fit the address");
      end
      if (WORD_BYTES < 1 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
         $error("WORD_BYTES must be a power of two");
      end
      if (HOLD_MAX >= (1 << LEN_W)) begin : g_bad_hold
         $error("HOLD_MAX must fit LEN_W");
      end
   endgenerate

   seq_state_e            state_q;
   ctrl_fields_t          dec, fields_q;
   err_code_e             chk_code;
   logic [ADDR_W-1:0]     reg_dst, res_dst;
   space_e                res_space, space_q, last_space_q;
   logic [SYS_ADDR_W-1:0] desc_q;
   logic [POOL_ID_W-1:0]  pool_id_q;
   logic                  start_q, err_q, zdst_q;
   err_code_e             err_code_q;
   logic                  idle_accept, grant_ok, src_load, dst_load;
   logic                  beat_en, cmpl_en;
   logic [ADDR_W-1:0]     dst_in, base_dst, last_dst;

   dma_ctrl_decode u_dec (
      .word   (ld_ctrl),
      .fields (dec)
   );

   generate
      if (REG_ADDR_W < ADDR_W) begin : g_reg_win
         assign reg_dst = {{(ADDR_W-REG_ADDR_W){1'b0}}, ld_dst[REG_ADDR_W-1:0]};
      end else begin : g_reg_full
         assign reg_dst = ld_dst;
      end
   endgenerate

   always_comb begin
      res_dst   = ld_dst;
      res_space = SP_MEM;
      unique case (dec.mode)
         DM_PCI:     res_space = SP_PCI;
         DM_REG: begin
            res_dst   = reg_dst;
            res_space = SP_REG;
         end
         DM_PREV: begin
            res_dst   = last_dst;
            res_space = last_space_q;
         end
         DM_NXT_SRC: res_dst = ld_next_desc + SRC_OFS;
         DM_NXT_DST: res_dst = ld_next_desc + DST_OFS;
         default: ;
      endcase
   end

   dma_desc_check #(
      .ADDR_W     (ADDR_W),
      .LEN_W      (LEN_W),
      .WORD_BYTES (WORD_BYTES),
      .HOLD_MAX   (HOLD_MAX)
   ) u_chk (
      .fields    (dec),
      .src       (ld_src),
      .dst       (res_dst),
      .dst_known (dec.mode != DM_POOL),
      .len       (ld_len),
      .code      (chk_code)
   );

   assign idle_accept = (state_q == ST_IDLE) && ld_valid && (chk_code == EC_NONE);
   assign grant_ok    = (state_q == ST_POOL) && pool_grant && pool_avail;
   assign src_load    = idle_accept;
   assign dst_load    = (idle_accept && (dec.mode != DM_POOL)) || grant_ok;
   assign dst_in      = (state_q == ST_POOL) ? pool_addr : res_dst;
   assign beat_en     = (state_q == ST_ACTIVE) && beat && !done;
   assign cmpl_en     = (state_q == ST_ACTIVE) && done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         fields_q     <= '0;
         desc_q       <= '0;
         pool_id_q    <= '0;
         space_q      <= SP_MEM;
         last_space_q <= SP_MEM;
         start_q      <= 1'b0;
         err_q        <= 1'b0;
         zdst_q       <= 1'b0;
         err_code_q   <= EC_NONE;
      end else begin
         start_q <= 1'b0;
         err_q   <= 1'b0;
         zdst_q  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (ld_valid) begin
                  if (chk_code != EC_NONE) begin
                     err_q      <= 1'b1;
                     err_code_q <= chk_code;
                  end else begin
                     fields_q  <= dec;
                     desc_q    <= ld_desc_addr;
                     pool_id_q <= ld_dst[POOL_ID_W-1:0];
                     space_q   <= res_space;
                     if (dec.mode == DM_POOL) begin
                        state_q <= ST_POOL;
                     end else begin
                        state_q <= ST_ACTIVE;
                        start_q <= 1'b1;
                     end
                  end
               end
            end
            ST_POOL: begin
               if (pool_grant) begin
                  if (pool_avail) begin
                     state_q <= ST_ACTIVE;
                     start_q <= 1'b1;
                     space_q <= SP_MEM;
                  end else begin
                     state_q <= ST_IDLE;
                     zdst_q  <= 1'b1;
                  end
               end
            end
            ST_ACTIVE: begin
               if (done) begin
                  state_q      <= ST_IDLE;
                  last_space_q <= space_q;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   dma_addr_unit #(
      .ADDR_W     (ADDR_W),
      .WORD_BYTES (WORD_BYTES)
   ) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_load   (src_load),
      .src_in     (ld_src),
      .dst_load   (dst_load),
      .dst_in     (dst_in),
      .beat_en    (beat_en),
      .cmpl_en    (cmpl_en),
      .hold_src   (fields_q.hold_src),
      .hold_dst   (fields_q.hold_dst),
      .src_q      (cur_src),
      .dst_q      (cur_dst),
      .base_q     (base_dst),
      .last_dst_q (last_dst)
   );

   dma_cmpl_unit #(
      .ADDR_W        (ADDR_W),
      .SYS_ADDR_W    (SYS_ADDR_W),
      .EVQ_W         (EVQ_W),
      .TX_ALIGN_BITS (TX_ALIGN_BITS)
   ) u_cmpl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmpl_en   (cmpl_en),
      .evq_on    (fields_q.evq_on_done),
      .no_status (fields_q.no_status),
      .tx_on     (fields_q.tx_on_done),
      .desc_addr (desc_q),
      .base_dst  (base_dst),
      .evq_push  (evq_push),
      .evq_data  (evq_data),
      .stat_set  (stat_set),
      .tx_enq    (tx_enq),
      .tx_addr   (tx_addr)
   );

   assign busy         = (state_q != ST_IDLE);
   assign pool_req     = (state_q == ST_POOL);
   assign pool_id      = pool_id_q;
   assign xfer_start   = start_q;
   assign err_pulse    = err_q;
   assign err_code     = err_code_q;
   assign zero_dst_evt = zdst_q;
   assign dst_space    = space_q;
   assign cksum_en     = busy && fields_q.cksum_en;
   assign cksum_clr    = busy && fields_q.cksum_clr;
   assign little_en    = busy && fields_q.little;

   // R12
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({xfer_start, err_pulse, zero_dst_evt}));

   // R12
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> !xfer_start);

   // R10
   err_code_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> (err_code != 3'd0 && !busy));

   // R4
   zero_dst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zero_dst_evt |-> ($past(pool_req) && !busy));

   // R12
   busy_load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ld_valid && !beat && !done && !pool_grant) |=> ($stable(cur_dst) && $stable(cur_src)));

endmodule

// File: tb/tb_dma_desc_seq.sv
`timescale 1ns/1ps
module tb_dma_desc_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_valid = 1'b0;
   logic [31:0] ld_ctrl = '0, ld_src = '0, ld_dst = '0, ld_desc_addr = '0, ld_next_desc = '0;
   logic [15:0] ld_len = '0;
   logic        beat = 1'b0, done = 1'b0;
   logic        pool_req, pool_grant = 1'b0, pool_avail = 1'b0;
   logic [3:0]  pool_id;
   logic [31:0] pool_addr = '0;
   logic        busy, xfer_start, cksum_en, cksum_clr, little_en;
   logic [31:0] cur_src, cur_dst, tx_addr;
   logic [1:0]  dst_space;
   logic        evq_push, stat_set, tx_enq, zero_dst_evt, err_pulse;
   logic [25:0] evq_data;
   logic [2:0]  err_code;

   always #2 clk = ~clk;

   dma_desc_seq dut (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ctrl(ld_ctrl), .ld_src(ld_src),
      .ld_dst(ld_dst), .ld_len(ld_len), .ld_desc_addr(ld_desc_addr), .ld_next_desc(ld_next_desc),
      .beat(beat), .done(done), .pool_req(pool_req), .pool_id(pool_id), .pool_grant(pool_grant),
      .pool_avail(pool_avail), .pool_addr(pool_addr), .busy(busy), .xfer_start(xfer_start),
      .cur_src(cur_src), .cur_dst(cur_dst), .dst_space(dst_space), .cksum_en(cksum_en),
      .cksum_clr(cksum_clr), .little_en(little_en), .evq_push(evq_push), .evq_data(evq_data),
      .stat_set(stat_set), .tx_enq(tx_enq), .tx_addr(tx_addr), .zero_dst_evt(zero_dst_evt),
      .err_pulse(err_pulse), .err_code(err_code)
   );

   typedef struct {
      int          kind;
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] c;
      logic [31:0] d;
      logic [2:0]  f;
      string       tag;
   } exp_t;

   localparam int K_START = 1, K_ERR = 2, K_ZDST = 3, K_CMPL = 4;

   exp_t scb[$];
   int   n_checks = 0;
   int   n_fail = 0;
   bit   finished = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push_start(input logic [31:0] d, s, sp, input string tag);
      exp_t e;
      e.kind = K_START; e.a = d; e.b = s; e.c = sp; e.d = '0; e.f = '0; e.tag = tag;
      scb.push_back(e);
   endtask

   task automatic push_err(input logic [2:0] code, input string tag);
      exp_t e;
      e.kind = K_ERR; e.a = {29'd0, code}; e.b = '0; e.c = '0; e.d = '0; e.f = '0; e.tag = tag;
      scb.push_back(e);
   endtask

   task automatic push_zdst(input string tag);
      exp_t e;
      e.kind = K_ZDST; e.a = '0; e.b = '0; e.c = '0; e.d = '0; e.f = '0; e.tag = tag;
      scb.push_back(e);
   endtask

   // f = {evq, stat, tx}
   task automatic push_cmpl(input logic [31:0] d, s, input logic [2:0] f,
                            input logic [31:0] desc, txa, input string tag);
      exp_t e;
      e.kind = K_CMPL; e.a = d; e.b = s; e.c = {6'd0, desc[31:6]}; e.d = txa; e.f = f; e.tag = tag;
      scb.push_back(e);
   endtask

   task automatic compare(input exp_t o);
      exp_t e;
      bit ok;
      if (scb.size() == 0) begin
         chk(1'b0, "R12 unexpected event", 32'(o.kind), 32'd0);
         return;
      end
      e = scb.pop_front();
      ok = (e.kind == o.kind);
      if (ok && o.kind == K_START) ok = (o.a == e.a) && (o.b == e.b) && (o.c == e.c);
      if (ok && o.kind == K_ERR)   ok = (o.a == e.a);
      if (ok && o.kind == K_CMPL) begin
         ok = (o.a == e.a) && (o.b == e.b) && (o.f == e.f);
         if (e.f[2]) ok = ok && (o.c == e.c);
         if (e.f[0]) ok = ok && (o.d == e.d);
      end
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual kind=%0d a=%h b=%h c=%h d=%h f=%b expected kind=%0d a=%h b=%h c=%h d=%h f=%b",
                  e.tag, o.kind, o.a, o.b, o.c, o.d, o.f, e.kind, e.a, e.b, e.c, e.d, e.f);
      end
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         exp_t o;
         o.tag = "";
         o.d = '0; o.c = '0; o.b = '0; o.a = '0; o.f = '0;
         if (xfer_start) begin
            o.kind = K_START; o.a = cur_dst; o.b = cur_src; o.c = {30'd0, dst_space};
            compare(o);
         end
         if (err_pulse) begin
            o.kind = K_ERR; o.a = {29'd0, err_code};
            compare(o);
         end
         if (zero_dst_evt) begin
            o.kind = K_ZDST;
            compare(o);
         end
         if (evq_push || stat_set || tx_enq) begin
            o.kind = K_CMPL; o.a = cur_dst; o.b = cur_src; o.c = {6'd0, evq_data};
            o.d = tx_addr; o.f = {evq_push, stat_set, tx_enq};
            compare(o);
         end
      end
   end

   task automatic do_load(input logic [31:0] c, s, d, input logic [15:0] l,
                          input logic [31:0] da, nd);
      ld_ctrl = c; ld_src = s; ld_dst = d; ld_len = l; ld_desc_addr = da; ld_next_desc = nd;
      ld_valid = 1'b1;
      @(negedge clk);
      ld_valid = 1'b0;
   endtask

   task automatic beats(input int n);
      for (int i = 0; i < n; i++) begin
         beat = 1'b1;
         @(negedge clk);
      end
      beat = 1'b0;
   endtask

   task automatic finish_xfer();
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      chk(1'b0, "watchdog", 32'd0, 32'd1);
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state
      chk(!busy && !xfer_start && !err_pulse && !evq_push && !stat_set && !tx_enq,
          "R12 reset outputs", {31'd0, busy}, 32'd0);
      chk(cur_dst == 32'd0, "R3 reset last dst", cur_dst, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // mode 000, checksum, evq, tx
      push_start(32'h1234, 32'h100, 0, "R2 mode000 start");
      do_load(32'h1500_0000, 32'h100, 32'h1234, 16'd16, 32'hDEAD_BEEF, 32'h0);
      chk(cksum_en && !cksum_clr && !little_en, "R1 cksum flags", {29'd0, cksum_en, cksum_clr, little_en}, 32'b100);
      beats(3);
      chk(cur_src == 32'h10C, "R5 src step", cur_src, 32'h10C);
      chk(cur_dst == 32'h1240, "R5 dst step", cur_dst, 32'h1240);
      push_cmpl(32'h1240, 32'h10C, 3'b111, 32'hDEAD_BEEF, 32'h1200, "R7 R8 R9 completion");
      finish_xfer();

      // mode 001 PCI, beat coinciding with done is dropped
      push_start(32'h9000_0010, 32'h40, 1, "R2 mode001 start");
      do_load(32'h0110_0000, 32'h40, 32'h9000_0010, 16'd8, 32'h1234_5678, 32'h0);
      beats(1);
      push_cmpl(32'h9000_0014, 32'h44, 3'b110, 32'h1234_5678, 32'h0, "R5 done wins over beat");
      beat = 1'b1;
      finish_xfer();
      beat = 1'b0;

      // mode 010 register window, hold dst, status inhibited
      push_start(32'h1234, 32'h500, 2, "R2 mode010 start");
      do_load(32'h23A0_0000, 32'h500, 32'hABCD_1234, 16'd64, 32'hCAFE_0040, 32'h0);
      chk(!cksum_clr && !cksum_en, "R1 hold redefines bits", {30'd0, cksum_en, cksum_clr}, 32'd0);
      beats(2);
      chk(cur_dst == 32'h1234, "R5 held dst", cur_dst, 32'h1234);
      chk(cur_src == 32'h508, "R5 src moves", cur_src, 32'h508);
      push_cmpl(32'h1238, 32'h508, 3'b100, 32'hCAFE_0040, 32'h0, "R6 R8 held dst advance, no status");
      finish_xfer();

      // mode 100 previous destination
      push_start(32'h1238, 32'h20, 2, "R3 mode100 start");
      do_load(32'h0140_0000, 32'h20, 32'h7777_0000, 16'd4, 32'h0, 32'h0);
      push_cmpl(32'h1238, 32'h20, 3'b110, 32'h0, 32'h0, "R3 mode100 done");
      finish_xfer();

      // modes 101 / 110
      push_start(32'h4004, 32'h30, 0, "R3 mode101 start");
      do_load(32'h0150_0000, 32'h30, 32'h0, 16'd4, 32'h0, 32'h4000);
      push_cmpl(32'h4004, 32'h30, 3'b110, 32'h0, 32'h0, "R3 mode101 done");
      finish_xfer();
      push_start(32'h4008, 32'h30, 0, "R3 mode110 start");
      do_load(32'h0160_0000, 32'h30, 32'h0, 16'd4, 32'h0, 32'h4000);
      push_cmpl(32'h4008, 32'h30, 3'b110, 32'h0, 32'h0, "R3 mode110 done");
      finish_xfer();

      // mode 011 pool available
      do_load(32'h0530_0000, 32'h60, 32'h0000_0005, 16'd4, 32'h0000_1000, 32'h0);
      chk(pool_req && busy && pool_id == 4'd5, "R4 pool request", {27'd0, pool_req, pool_id}, 32'h15);
      @(negedge clk);
      chk(pool_req, "R4 request held", {31'd0, pool_req}, 32'd1);
      push_start(32'h8040, 32'h60, 0, "R4 pool start");
      pool_grant = 1'b1; pool_avail = 1'b1; pool_addr = 32'h8040;
      @(negedge clk);
      pool_grant = 1'b0;
      push_cmpl(32'h8040, 32'h60, 3'b111, 32'h0000_1000, 32'h8040, "R4 R9 pool done");
      finish_xfer();

      // mode 011 pool empty
      do_load(32'h0130_0000, 32'h60, 32'h0000_0002, 16'd4, 32'h0, 32'h0);
      push_zdst("R4 zero destination");
      pool_grant = 1'b1; pool_avail = 1'b0;
      @(negedge clk);
      pool_grant = 1'b0;
      chk(!busy && !pool_req, "R4 idle after empty pool", {30'd0, busy, pool_req}, 32'd0);

      // load ignored while busy
      push_start(32'h2000, 32'h0, 0, "R12 base start");
      do_load(32'h0100_0000, 32'h0, 32'h2000, 16'd4, 32'h0, 32'h0);
      do_load(32'hC070_0000, 32'h3, 32'h3000, 16'd4, 32'h0, 32'h0);
      chk(cur_dst == 32'h2000 && cur_src == 32'h0, "R12 busy load ignored", cur_dst, 32'h2000);
      push_cmpl(32'h2000, 32'h0, 3'b110, 32'h0, 32'h0, "R12 base done");
      finish_xfer();

      // errors
      push_err(3'd1, "R10 reserved bits");
      do_load(32'h8100_0000, 32'h0, 32'h0, 16'd4, 32'h0, 32'h0);
      push_err(3'd2, "R10 R8 reserved mode with status inhibit");
      do_load(32'h00F0_0000, 32'h0, 32'h0, 16'd4, 32'h0, 32'h0);
      push_err(3'd1, "R10 priority");
      do_load(32'h4870_0000, 32'h2, 32'h0, 16'd4, 32'h0, 32'h0);
      push_err(3'd3, "R11 src misaligned");
      do_load(32'h0800_0000, 32'h102, 32'h200, 16'd4, 32'h0, 32'h0);
      push_err(3'd3, "R11 next-field dst misaligned");
      do_load(32'h0850_0000, 32'h100, 32'h0, 16'd4, 32'h0, 32'h4002);
      push_err(3'd4, "R11 hold too long");
      do_load(32'h1200_0000, 32'h0, 32'h0, 16'd256, 32'h0, 32'h0);
      chk(!busy, "R10 no start after error", {31'd0, busy}, 32'd0);

      // hold src at the length limit
      push_start(32'h700, 32'h600, 0, "R11 len 252 accepted");
      do_load(32'h1300_0000, 32'h600, 32'h700, 16'd252, 32'h0, 32'h0);
      beats(1);
      chk(cur_src == 32'h600 && cur_dst == 32'h704, "R5 held src", cur_src, 32'h600);
      push_cmpl(32'h704, 32'h604, 3'b110, 32'h0, 32'h0, "R6 held src advance");
      finish_xfer();

      // little-endian aligned, pool address not checked
      push_start(32'h200, 32'h100, 0, "R11 aligned LE accepted");
      do_load(32'h0800_0000, 32'h100, 32'h200, 16'd4, 32'h0, 32'h0);
      chk(little_en, "R1 little endian flag", {31'd0, little_en}, 32'd1);
      push_cmpl(32'h200, 32'h100, 3'b010, 32'h0, 32'h0, "R8 LE done");
      finish_xfer();

      repeat (3) @(negedge clk);
      chk(scb.size() == 0, "R12 all events seen", 32'(scb.size()), 32'd0);
      report();
   end

endmodule